// File: doc/BRIEF.md
# Branch Flush and Target Restart Controller

This block handles control hazards for a five-stage in-order pipeline with two decode stages (D1, D2) ahead of execute. Fetch always continues in sequential order past a branch, as if the branch will not be taken. When a branch reaches execute, the block asks fetch for the target bytes in that same cycle. It does this before the outcome is known, so the target fetch overlaps the resolution.

When execute reports the branch as taken, or the instruction is a call, the block clears the valid bits of the two younger instructions in D1 and D2 that same cycle. It also cancels any hazard stall on those stages. On the next cycle it sends a one-cycle flush pulse to the prefetch queue and tells D1 to restart at the target address. A taken branch therefore costs three cycles in all: its own cycle plus two bubbles. When the branch is not taken, the target bytes are dropped, no flush or restart happens, and the branch costs one cycle.

Three counters record taken branches, not-taken branches and the bubble cycles that flushes cause, so the cycle cost can be seen from outside.

Top module: `bfc_top`

## Requirements
- R1: In every cycle with `ex_br_vld_i` high, `spec_fetch_req_o` is high and `spec_fetch_addr_o` equals `ex_target_i`, whatever the outcome. With no branch, `spec_fetch_req_o` is low.
- R2: In a cycle where a valid branch resolves taken, `d1_vld_o` and `d2_vld_o` are 0 whatever their inputs.
- R3: In a not-taken branch cycle, and in any cycle without a branch, `d1_vld_o` and `d2_vld_o` follow `d1_vld_i` and `d2_vld_i`.
- R4: In the cycle after a taken resolution, `pq_flush_o` and `restart_o` are high for exactly one cycle, and `restart_pc_o` holds the target presented at resolution.
- R5: After a not-taken resolution, `restart_o` and `pq_flush_o` stay low in the next cycle, so the speculative target is discarded.
- R6: When `hz_stall_i` meets a taken resolution, `stall_o` is 0. Otherwise `stall_o` follows `hz_stall_i`.
- R7: A valid branch with `ex_is_call_i` high is treated as taken even when `ex_br_taken_i` is low, with the same flush, restart and cost.
- R8: Each taken resolution adds 1 to `taken_cnt_o` and 2 to `bubble_cnt_o`. Each not-taken resolution adds 1 to `nt_cnt_o` and leaves `bubble_cnt_o` unchanged. The counts appear on the cycle after resolution.
- R9: While `rst_n` is low, `pq_flush_o`, `restart_o`, `restart_pc_o` and all three counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_br_vld_i | input | 1 | A branch or call is in execute this cycle |
| ex_br_taken_i | input | 1 | Resolved outcome of the branch |
| ex_is_call_i | input | 1 | The instruction in execute is a call |
| ex_target_i | input | AW | Branch target address |
| d1_vld_i | input | 1 | D1 holds a valid instruction |
| d2_vld_i | input | 1 | D2 holds a valid instruction |
| hz_stall_i | input | 1 | Stall request from the hazard unit |
| spec_fetch_req_o | output | 1 | Speculative target fetch request |
| spec_fetch_addr_o | output | AW | Speculative target fetch address |
| d1_vld_o | output | 1 | D1 valid after the flush |
| d2_vld_o | output | 1 | D2 valid after the flush |
| stall_o | output | 1 | Stall after flush priority is applied |
| pq_flush_o | output | 1 | One-cycle flush pulse to the prefetch queue |
| restart_o | output | 1 | D1 restarts at `restart_pc_o` |
| restart_pc_o | output | AW | Restart address |
| taken_cnt_o | output | CW | Taken branch count |
| nt_cnt_o | output | CW | Not-taken branch count |
| bubble_cnt_o | output | CW | Bubble cycle count |

## Verification
The hardest case to reach is a hazard stall that arrives in the same cycle as a taken resolution, while both decode stages hold valid instructions. It needs all three inputs to line up at one edge. A dedicated task drives `hz_stall_i`, both valid bits and a taken branch together. It then checks that the stall is dropped and both stages are cleared. A second task does the same with a call whose taken bit is low. The next cycle is checked separately to confirm that the restart pulse ends after one cycle.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
  // Cycles a resolved branch occupies, including its own execute cycle.
  localparam int unsigned COST_TAKEN    = 3;
  localparam int unsigned COST_NOTTAKEN = 1;

  function automatic int unsigned br_cost(input logic taken);
    return taken ? COST_TAKEN : COST_NOTTAKEN;
  endfunction

  function automatic int unsigned br_bubbles(input logic taken);
    return br_cost(taken) - 1;
  endfunction
endpackage

// File: rtl/bfc_resolve.sv
module bfc_resolve (
  input  logic ex_br_vld_i,
  input  logic ex_br_taken_i,
  input  logic ex_is_call_i,
  input  logic d1_vld_i,
  input  logic d2_vld_i,
  input  logic hz_stall_i,
  output logic flush_o,
  output logic nt_o,
  output logic d1_vld_o,
  output logic d2_vld_o,
  output logic stall_o
);
  logic eff_taken;

  always_comb begin
    eff_taken = ex_br_taken_i | ex_is_call_i;
    flush_o   = ex_br_vld_i & eff_taken;
    nt_o      = ex_br_vld_i & ~eff_taken;
    d1_vld_o  = d1_vld_i & ~flush_o;
    d2_vld_o  = d2_vld_i & ~flush_o;
    stall_o   = hz_stall_i & ~flush_o;
  end

  always_comb begin
    // R3
    pass_chk: assert (flush_o || (d1_vld_o == d1_vld_i && d2_vld_o == d2_vld_i));
  end
endmodule

// File: rtl/bfc_restart.sv
module bfc_restart #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic [AW-1:0] target_i,
  output logic          pq_flush_o,
  output logic          restart_o,
  output logic [AW-1:0] restart_pc_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pq_flush_o   <= 1'b0;
      restart_o    <= 1'b0;
      restart_pc_o <= '0;
    end else begin
      pq_flush_o <= flush_i;
      restart_o  <= flush_i;
      if (flush_i) restart_pc_o <= target_i;
    end
  end

  // R4
  restart_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (restart_o && pq_flush_o && restart_pc_o == $past(target_i)));
  // R5
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_i |=> (!restart_o && !pq_flush_o));
endmodule

// File: rtl/bfc_perf.sv
module bfc_perf #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          taken_i,
  input  logic          nt_i,
  output logic [CW-1:0] taken_cnt_o,
  output logic [CW-1:0] nt_cnt_o,
  output logic [CW-1:0] bubble_cnt_o
);
  import bfc_pkg::*;
  localparam logic [CW-1:0] BUB_INC = CW'(br_bubbles(1'b1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taken_cnt_o  <= '0;
      nt_cnt_o     <= '0;
      bubble_cnt_o <= '0;
    end else begin
      if (taken_i) begin
        taken_cnt_o  <= taken_cnt_o + 1'b1;
        bubble_cnt_o <= bubble_cnt_o + BUB_INC;
      end
      if (nt_i) nt_cnt_o <= nt_cnt_o + 1'b1;
    end
  end

  // R8
  bubble_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken_i |=> bubble_cnt_o == $past(bubble_cnt_o) + CW'(2));
  // R8
  nt_no_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nt_i && !taken_i) |=> (bubble_cnt_o == $past(bubble_cnt_o) &&
                            nt_cnt_o == $past(nt_cnt_o) + 1'b1));
endmodule

// File: rtl/bfc_top.sv
module bfc_top #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ex_br_vld_i,
  input  logic          ex_br_taken_i,
  input  logic          ex_is_call_i,
  input  logic [AW-1:0] ex_target_i,
  input  logic          d1_vld_i,
  input  logic          d2_vld_i,
  input  logic          hz_stall_i,
  output logic          spec_fetch_req_o,
  output logic [AW-1:0] spec_fetch_addr_o,
  output logic          d1_vld_o,
  output logic          d2_vld_o,
  output logic          stall_o,
  output logic          pq_flush_o,
  output logic          restart_o,
  output logic [AW-1:0] restart_pc_o,
  output logic [CW-1:0] taken_cnt_o,
  output logic [CW-1:0] nt_cnt_o,
  output logic [CW-1:0] bubble_cnt_o
);
  logic flush_evt;
  logic nt_evt;

  assign spec_fetch_req_o  = ex_br_vld_i;
  assign spec_fetch_addr_o = ex_target_i;

  bfc_resolve u_res (
    .ex_br_vld_i  (ex_br_vld_i),
    .ex_br_taken_i(ex_br_taken_i),
    .ex_is_call_i (ex_is_call_i),
    .d1_vld_i     (d1_vld_i),
    .d2_vld_i     (d2_vld_i),
    .hz_stall_i   (hz_stall_i),
    .flush_o      (flush_evt),
    .nt_o         (nt_evt),
    .d1_vld_o     (d1_vld_o),
    .d2_vld_o     (d2_vld_o),
    .stall_o      (stall_o)
  );

  bfc_restart #(.AW(AW)) u_rst (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (flush_evt),
    .target_i    (ex_target_i),
    .pq_flush_o  (pq_flush_o),
    .restart_o   (restart_o),
    .restart_pc_o(restart_pc_o)
  );

  bfc_perf #(.CW(CW)) u_perf (
    .clk         (clk),
    .rst_n       (rst_n),
    .taken_i     (flush_evt),
    .nt_i        (nt_evt),
    .taken_cnt_o (taken_cnt_o),
    .nt_cnt_o    (nt_cnt_o),
    .bubble_cnt_o(bubble_cnt_o)
  );

  // R2
  kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_br_vld_i && (ex_br_taken_i || ex_is_call_i)) |-> (!d1_vld_o && !d2_vld_o));
  // R6
  stall_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_br_vld_i && (ex_br_taken_i || ex_is_call_i)) |-> !stall_o);
  // R7
  call_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_br_vld_i && ex_is_call_i) |=> restart_o);
  // R1
  spec_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spec_fetch_req_o == ex_br_vld_i);
endmodule

// File: tb/sim_bfc_top.sv
`timescale 1ns/1ps
module sim_bfc_top;
  localparam int AW = 32;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic ex_br_vld, ex_br_taken, ex_is_call, d1_vi, d2_vi, hz_stall;
  logic [AW-1:0] ex_target;
  logic spec_req, d1_vo, d2_vo, stall_o, pq_flush, restart;
  logic [AW-1:0] spec_addr, restart_pc;
  logic [CW-1:0] tk_cnt, nt_cnt, bub_cnt;

  int n_chk = 0, n_fail = 0;
  int exp_tk = 0, exp_nt = 0, exp_bub = 0;

  always #2 clk = ~clk;

  bfc_top #(.AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ex_br_vld_i(ex_br_vld), .ex_br_taken_i(ex_br_taken), .ex_is_call_i(ex_is_call),
    .ex_target_i(ex_target), .d1_vld_i(d1_vi), .d2_vld_i(d2_vi), .hz_stall_i(hz_stall),
    .spec_fetch_req_o(spec_req), .spec_fetch_addr_o(spec_addr),
    .d1_vld_o(d1_vo), .d2_vld_o(d2_vo), .stall_o(stall_o),
    .pq_flush_o(pq_flush), .restart_o(restart), .restart_pc_o(restart_pc),
    .taken_cnt_o(tk_cnt), .nt_cnt_o(nt_cnt), .bubble_cnt_o(bub_cnt)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ex_br_vld = 0; ex_br_taken = 0; ex_is_call = 0; hz_stall = 0;
    d1_vi = 0; d2_vi = 0; ex_target = '0;
  endtask

  task automatic chk_counters();
    chk(tk_cnt == CW'(exp_tk), "R8 taken count", tk_cnt, exp_tk);
    chk(nt_cnt == CW'(exp_nt), "R8 not-taken count", nt_cnt, exp_nt);
    chk(bub_cnt == CW'(exp_bub), "R8 bubble count", bub_cnt, exp_bub);
  endtask

  // One branch in execute for a single cycle, then the following cycles checked.
  task automatic run_branch(input bit tk, input bit call, input bit st,
                            input bit v1, input bit v2, input logic [AW-1:0] tgt,
                            input string tag);
    bit eff = tk | call;
    @(negedge clk);
    ex_br_vld = 1; ex_br_taken = tk; ex_is_call = call; hz_stall = st;
    d1_vi = v1; d2_vi = v2; ex_target = tgt;
    #1;
    chk(spec_req == 1'b1, {tag, " R1 spec req"}, spec_req, 1);
    chk(spec_addr == tgt, {tag, " R1 spec addr"}, spec_addr, tgt);
    chk(d1_vo == (v1 & ~eff), {tag, " R2/R3 d1 valid"}, d1_vo, v1 & ~eff);
    chk(d2_vo == (v2 & ~eff), {tag, " R2/R3 d2 valid"}, d2_vo, v2 & ~eff);
    chk(stall_o == (st & ~eff), {tag, " R6 stall"}, stall_o, st & ~eff);
    @(posedge clk); #1;
    idle();
    if (eff) begin exp_tk++; exp_bub += 3 - 1; end else exp_nt++;
    chk(restart == eff, {tag, " R4/R5 restart"}, restart, eff);
    chk(pq_flush == eff, {tag, " R4/R5 pq flush"}, pq_flush, eff);
    if (eff) chk(restart_pc == tgt, {tag, " R4 restart pc"}, restart_pc, tgt);
    chk_counters();
    @(posedge clk); #1;
    chk(!restart && !pq_flush, {tag, " R4 single pulse"}, {restart, pq_flush}, 0);
  endtask

  task automatic t_reset();
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(!pq_flush && !restart && restart_pc == '0, "R9 reset outputs", {pq_flush, restart}, 0);
    chk_counters();
    chk(spec_req == 1'b0, "R1 no branch no request", spec_req, 0);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_no_branch();
    @(negedge clk);
    d1_vi = 1; d2_vi = 0; hz_stall = 1; #1;
    chk(d1_vo == 1 && d2_vo == 0, "R3 passthrough no branch", {d1_vo, d2_vo}, 2'b10);
    chk(stall_o == 1, "R6 stall passes alone", stall_o, 1);
    @(negedge clk); idle();
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_no_branch();
        run_branch(0, 0, 0, 1, 1, 32'h0000_1000, "nt_both");
        run_branch(1, 0, 0, 1, 1, 32'hDEAD_BEE0, "tk_both");
        run_branch(1, 0, 0, 1, 0, 32'h0000_4444, "tk_d1only");
        run_branch(0, 0, 1, 0, 1, 32'h1234_5678, "nt_stall");
        run_branch(1, 0, 1, 1, 1, 32'hCAFE_0010, "tk_stall");
        run_branch(0, 1, 0, 1, 1, 32'h0000_8000, "R7 call");
        run_branch(0, 1, 1, 1, 1, 32'hFFFF_FFFC, "R7 call_stall");
        run_branch(0, 0, 0, 0, 0, 32'h0000_0040, "nt_empty");
      end
      begin
        repeat (2000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule